// File: doc/BRIEF.md
# Bus Debug Trigger Comparator Sequencer

This block watches a processor bus one cycle at a time and raises trigger events by a mode chosen from outside. Two address comparators, A and B, are used in each mode. In some modes the low byte of B compares the data instead, and an optional read/write qualifier can be added. The modes are: B after an earlier A, address-plus-data and address-plus-data-mismatch in the same cycle, data capture on every B hit, capture on B only after an A hit, and inclusive inside-range and outside-range address windows.

A run starts with a one-cycle arm pulse. In the two capture modes each trigger also pushes the bus data byte into a capture store of fixed depth. The run stops when that store is full, and it stays stopped until the next arm. The capture strobe and data byte come out of the block so that a trace buffer elsewhere can keep them. Every result is registered and appears one clock after the bus cycle that caused it.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset `trig_o`, `cap_valid_o` and `run_active_o` are 0. No trigger or capture occurs while the run is inactive.
- R2: An `arm` pulse sets `run_active_o`, clears the A-seen flag and clears the capture count in the next cycle. The bus is not evaluated in the arm cycle.
- R3: With `mode`=0 (A then B), a valid cycle whose address equals `cmp_a` sets the A-seen flag. A later valid cycle whose address equals `cmp_b` triggers, however many cycles lie between. A B hit in the same cycle as the first A hit does not trigger.
- R4: With `mode`=1, a trigger needs address equal to `cmp_a` and data equal to `cmp_b[DW-1:0]` in the same valid cycle. The upper bits of `cmp_b` are ignored.
- R5: With `mode`=2, a trigger needs address equal to `cmp_a` and data unequal to `cmp_b[DW-1:0]` in the same valid cycle.
- R6: In modes 1 and 2, when `rw_en`=1, the trigger also needs `bus_rnw` equal to `rw_val`. When `rw_en`=0, `bus_rnw` is ignored.
- R7: With `mode`=3, every valid cycle with address equal to `cmp_b` triggers and pulses `cap_valid_o` with `cap_data_o` equal to that cycle's `bus_data`.
- R8: With `mode`=4, B hits trigger and capture only after an earlier A hit, with the same A-seen rule as R3.
- R9: In modes 3 and 4, after DEPTH (default 8) captures `run_active_o` drops in the same cycle as the last capture strobe. There are then no further triggers or captures until the next arm.
- R10: With `mode`=5, a trigger fires when `cmp_a` ≤ address ≤ `cmp_b`, with both bounds included.
- R11: With `mode`=6, a trigger fires when the address is below `cmp_a` or above `cmp_b`.
- R12: Cycles with `bus_valid`=0 have no effect. `mode`=7 never triggers.
- R13: `trig_o` and `cap_valid_o` are registered. Each is high for exactly the one cycle after the bus cycle that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus cycle qualifier |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data byte |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| mode | input | 3 | Trigger mode select (0..7) |
| cmp_a | input | AW | Comparator A value |
| cmp_b | input | AW | Comparator B value (low DW bits serve as data in modes 1 and 2) |
| rw_val | input | 1 | Required read/write value |
| rw_en | input | 1 | Enables the read/write qualifier |
| arm | input | 1 | Starts a new run |
| trig_o | output | 1 | Trigger pulse |
| cap_valid_o | output | 1 | Capture strobe |
| cap_data_o | output | DW | Captured data byte |
| run_active_o | output | 1 | Run in progress |

## Verification
`trig_o`, `cap_valid_o` and `cap_data_o` belong to the bus cycle sampled at the previous rising edge. `run_active_o` responds to an arm at the next edge, and it falls at the same edge that shows the final capture. The bench drives inputs on falling edges and steps a behavioural model at each rising edge. It compares every output at the next falling edge, so each result is checked exactly one clock after its bus cycle. A-seen memory across idle gaps, the full-store stop and the re-arm are exercised by directed sequences. A random phase then mixes modes, near-boundary addresses and stray arm pulses.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

   typedef enum logic [2:0] {
      MODE_A_THEN_B     = 3'd0,
      MODE_FULL_EQ      = 3'd1,
      MODE_FULL_NE      = 3'd2,
      MODE_STORE_B      = 3'd3,
      MODE_A_THEN_STORE = 3'd4,
      MODE_IN_RANGE     = 3'd5,
      MODE_OUT_RANGE    = 3'd6,
      MODE_OFF          = 3'd7
   } trig_mode_e;

   function automatic logic mode_stores(trig_mode_e m);
      return (m == MODE_STORE_B) || (m == MODE_A_THEN_STORE);
   endfunction

   function automatic logic mode_sequenced(trig_mode_e m);
      return (m == MODE_A_THEN_B) || (m == MODE_A_THEN_STORE);
   endfunction

endpackage

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter bit RANGE_EN = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   input  logic          rnw,
   input  logic [AW-1:0] ref_a,
   input  logic [AW-1:0] ref_b,
   input  logic          rw_val,
   input  logic          rw_en,
   output logic          a_eq,
   output logic          b_eq,
   output logic          data_eq,
   output logic          rw_ok,
   output logic          in_win,
   output logic          out_win
);

   assign a_eq    = (addr == ref_a);
   assign b_eq    = (addr == ref_b);
   assign data_eq = (data == ref_b[DW-1:0]);
   assign rw_ok   = !rw_en || (rnw == rw_val);

   generate
      if (RANGE_EN) begin : g_range
         logic ge_a;
         logic le_b;
         assign ge_a    = (addr >= ref_a);
         assign le_b    = (addr <= ref_b);
         assign in_win  = ge_a && le_b;
         assign out_win = !ge_a || !le_b;
      end else begin : g_no_range
         assign in_win  = 1'b0;
         assign out_win = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dbg_seq_flag.sv
module dbg_seq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set,
   output logic seen
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   seen <= 1'b0;
      else if (clr) seen <= 1'b0;
      else if (set) seen <= 1'b1;
   end

   p_seen_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !clr) |=> seen);

   p_seen_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !seen);

endmodule

// File: rtl/dbg_cap_fill.sv
module dbg_cap_fill #(
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic push,
   output logic running
);

   logic [CW-1:0] fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q  <= '0;
         running <= 1'b0;
      end else if (start) begin
         fill_q  <= '0;
         running <= 1'b1;
      end else if (push && running) begin
         fill_q <= fill_q + 1'b1;
         if (fill_q == CW'(DEPTH - 1)) running <= 1'b0;
      end
   end

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= CW'(DEPTH));

   p_full_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == CW'(DEPTH) && !start) |=> ($stable(fill_q) && !running));

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
   import dbg_trig_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter int DEPTH    = 8,
   parameter bit RANGE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_valid,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_data,
   input  logic          bus_rnw,
   input  logic [2:0]    mode,
   input  logic [AW-1:0] cmp_a,
   input  logic [AW-1:0] cmp_b,
   input  logic          rw_val,
   input  logic          rw_en,
   input  logic          arm,
   output logic          trig_o,
   output logic          cap_valid_o,
   output logic [DW-1:0] cap_data_o,
   output logic          run_active_o
);

   generate
      if (DW > AW) begin : g_bad_dw
         $error("dbg_trig_seq: DW must not exceed AW");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("dbg_trig_seq: DEPTH must be at least 1");
      end
   endgenerate

   trig_mode_e mode_e;
   assign mode_e = trig_mode_e'(mode);

   logic a_eq, b_eq, data_eq, rw_ok, in_win, out_win;
   logic seen, eval, hit, store, push, set_seen;

   dbg_addr_cmp #(.AW(AW), .DW(DW), .RANGE_EN(RANGE_EN)) i_cmp (
      .addr   (bus_addr),
      .data   (bus_data),
      .rnw    (bus_rnw),
      .ref_a  (cmp_a),
      .ref_b  (cmp_b),
      .rw_val (rw_val),
      .rw_en  (rw_en),
      .a_eq   (a_eq),
      .b_eq   (b_eq),
      .data_eq(data_eq),
      .rw_ok  (rw_ok),
      .in_win (in_win),
      .out_win(out_win)
   );

   assign eval = run_active_o && bus_valid && !arm;

   always_comb begin
      unique case (mode_e)
         MODE_A_THEN_B,
         MODE_A_THEN_STORE: hit = b_eq && seen;
         MODE_FULL_EQ:      hit = a_eq && data_eq && rw_ok;
         MODE_FULL_NE:      hit = a_eq && !data_eq && rw_ok;
         MODE_STORE_B:      hit = b_eq;
         MODE_IN_RANGE:     hit = in_win;
         MODE_OUT_RANGE:    hit = out_win;
         default:           hit = 1'b0;
      endcase
   end

   assign store    = mode_stores(mode_e);
   assign push     = eval && hit && store;
   assign set_seen = eval && a_eq && mode_sequenced(mode_e);

   dbg_seq_flag i_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (arm),
      .set  (set_seen),
      .seen (seen)
   );

   dbg_cap_fill #(.DEPTH(DEPTH)) i_fill (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (arm),
      .push   (push),
      .running(run_active_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_o      <= 1'b0;
         cap_valid_o <= 1'b0;
         cap_data_o  <= '0;
      end else begin
         trig_o      <= eval && hit;
         cap_valid_o <= push;
         if (push) cap_data_o <= bus_data;
      end
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_active_o || arm) |=> (!trig_o && !cap_valid_o));

   p_arm_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> run_active_o);

   p_valid_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !trig_o);

   p_cap_is_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid_o |-> trig_o);

   p_off_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd7) |=> !trig_o);

endmodule

// File: tb/test_dbg_trig_seq.sv
module test_dbg_trig_seq;

   localparam int AW    = 16;
   localparam int DW    = 8;
   localparam int DEPTH = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_data = '0;
   logic          bus_rnw = 1'b0;
   logic [2:0]    mode = 3'd7;
   logic [AW-1:0] cmp_a = '0;
   logic [AW-1:0] cmp_b = '0;
   logic          rw_val = 1'b0;
   logic          rw_en = 1'b0;
   logic          arm = 1'b0;
   logic          trig_o, cap_valid_o, run_active_o;
   logic [DW-1:0] cap_data_o;

   always #2 clk = ~clk;

   dbg_trig_seq #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_dbg_trig_seq (
      .clk, .rst_n, .bus_valid, .bus_addr, .bus_data, .bus_rnw, .mode,
      .cmp_a, .cmp_b, .rw_val, .rw_en, .arm,
      .trig_o, .cap_valid_o, .cap_data_o, .run_active_o
   );

   int    errors = 0;
   int    checks = 0;
   int    cycles = 0;
   bit    done = 0;
   string cur_req = "R1";

   bit          m_seen, m_run, m_trig, m_cv;
   int          m_cnt;
   logic [DW-1:0] m_cd;

   // behavioural reference, stepped on every rising edge
   always @(posedge clk) begin
      bit am, bm, dm, rwok, hit, st;
      if (!rst_n) begin
         m_seen = 0; m_run = 0; m_trig = 0; m_cv = 0; m_cnt = 0; m_cd = '0;
      end else if (arm) begin
         m_seen = 0; m_run = 1; m_cnt = 0; m_trig = 0; m_cv = 0;
      end else begin
         am = (bus_addr == cmp_a);
         bm = (bus_addr == cmp_b);
         dm = (bus_data == cmp_b[DW-1:0]);
         rwok = !rw_en || (bus_rnw == rw_val);
         hit = 0; st = 0;
         if (m_run && bus_valid) begin
            case (mode)
               3'd0: hit = bm && m_seen;
               3'd1: hit = am && dm && rwok;
               3'd2: hit = am && !dm && rwok;
               3'd3: begin hit = bm; st = 1; end
               3'd4: begin hit = bm && m_seen; st = 1; end
               3'd5: hit = (bus_addr >= cmp_a) && (bus_addr <= cmp_b);
               3'd6: hit = (bus_addr < cmp_a) || (bus_addr > cmp_b);
               default: hit = 0;
            endcase
            if ((mode == 3'd0 || mode == 3'd4) && am) m_seen = 1;
         end
         m_trig = hit;
         m_cv = hit && st;
         if (hit && st) begin
            m_cd = bus_data;
            m_cnt++;
            if (m_cnt == DEPTH) m_run = 0;
         end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cycles);
      end
   endtask

   // comparison one clock after each bus cycle, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "trig_o", trig_o, m_trig);
         chk(cur_req, "cap_valid_o", cap_valid_o, m_cv);
         chk(cur_req, "run_active_o", run_active_o, m_run);
         if (m_cv) chk(cur_req, "cap_data_o", cap_data_o, m_cd);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic bus(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic rnw);
      @(negedge clk);
      bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_rnw = rnw;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_arm();
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   initial begin
      idle(2);
      // R1: reset values
      chk("R1", "reset trig", trig_o, 0);
      chk("R1", "reset cap", cap_valid_o, 0);
      chk("R1", "reset run", run_active_o, 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: B hits with no run armed are ignored
      cur_req = "R1"; mode = 3'd3; cmp_b = 16'h2000;
      bus(16'h2000, 8'h11, 0); bus(16'h2000, 8'h12, 0);

      // R3: A then B with gaps
      cur_req = "R3"; mode = 3'd0; cmp_a = 16'h1000; cmp_b = 16'h2000;
      do_arm();
      bus(16'h2000, 8'h00, 0);
      bus(16'h1000, 8'h00, 0);
      idle(6);
      bus(16'h2000, 8'h00, 0);
      bus(16'h2000, 8'h00, 0);
      // R3: A and B equal, first hit alone does not trigger
      cmp_b = 16'h1000;
      do_arm();
      bus(16'h1000, 8'h00, 0);
      bus(16'h1000, 8'h00, 0);
      // R2: re-arm forgets A
      cur_req = "R2"; cmp_b = 16'h2000;
      do_arm();
      bus(16'h2000, 8'h00, 0);

      // R4: address plus data, upper B bits ignored
      cur_req = "R4"; mode = 3'd1; cmp_a = 16'h3000; cmp_b = 16'hAB55;
      do_arm();
      bus(16'h3000, 8'h55, 0);
      bus(16'h3000, 8'h56, 1);
      bus(16'h3001, 8'h55, 0);
      bus(16'hAB55, 8'h55, 0);
      // R6: read/write qualifier
      cur_req = "R6"; rw_en = 1; rw_val = 1;
      bus(16'h3000, 8'h55, 0);
      bus(16'h3000, 8'h55, 1);
      rw_en = 0;
      bus(16'h3000, 8'h55, 0);
      // R5: data mismatch mode
      cur_req = "R5"; mode = 3'd2;
      bus(16'h3000, 8'h55, 0);
      bus(16'h3000, 8'h00, 0);
      rw_en = 1; rw_val = 0;
      bus(16'h3000, 8'h00, 1);
      bus(16'h3000, 8'h01, 0);
      rw_en = 0;

      // R10: inclusive window
      cur_req = "R10"; mode = 3'd5; cmp_a = 16'h0100; cmp_b = 16'h01FF;
      bus(16'h00FF, 0, 0); bus(16'h0100, 0, 0); bus(16'h0150, 0, 0);
      bus(16'h01FF, 0, 0); bus(16'h0200, 0, 0);
      // R11: outside window
      cur_req = "R11"; mode = 3'd6;
      bus(16'h00FF, 0, 0); bus(16'h0100, 0, 0); bus(16'h01FF, 0, 0);
      bus(16'h0200, 0, 0); bus(16'h0000, 0, 0);

      // R12: invalid cycles and off mode
      cur_req = "R12";
      @(negedge clk);
      bus_valid = 0; bus_addr = 16'h0000;
      idle(3);
      mode = 3'd7;
      bus(16'h0000, 0, 0); bus(16'h0150, 0, 0);

      // R7, R9: store on every B until full
      cur_req = "R7"; mode = 3'd3; cmp_b = 16'h4444;
      do_arm();
      for (int i = 0; i < 6; i++) begin
         bus(16'h4444, 8'(8'hA0 + i), 0);
         bus(16'h4445, 8'hEE, 0);
      end
      cur_req = "R9";
      for (int i = 0; i < 5; i++) bus(16'h4444, 8'(8'hC0 + i), 1);
      idle(2);
      chk("R9", "run after full", run_active_o, 0);
      do_arm();
      chk("R9", "run after re-arm", run_active_o, 1);
      bus(16'h4444, 8'h77, 0);

      // R8: A then store B
      cur_req = "R8"; mode = 3'd4; cmp_a = 16'h5000; cmp_b = 16'h6000;
      do_arm();
      bus(16'h6000, 8'h01, 0);
      bus(16'h5000, 8'h02, 0);
      idle(3);
      for (int i = 0; i < 10; i++) bus(16'h6000, 8'(i), 0);

      // R13 plus mixed: random traffic with occasional arm
      cur_req = "R13";
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         arm = ($urandom_range(0, 31) == 0);
         if ($urandom_range(0, 63) == 0) mode = 3'($urandom_range(0, 7));
         cmp_a = 16'h0800; cmp_b = 16'h0810;
         case ($urandom_range(0, 4))
            0: bus_addr = cmp_a;
            1: bus_addr = cmp_b;
            2: bus_addr = cmp_a - 1;
            3: bus_addr = cmp_b + 1;
            default: bus_addr = 16'($urandom);
         endcase
         bus_valid = $urandom_range(0, 1);
         bus_data = 8'($urandom_range(0, 3) == 0 ? 8'h10 : $urandom);
         bus_rnw = $urandom_range(0, 1);
         rw_en = $urandom_range(0, 1);
         rw_val = $urandom_range(0, 1);
      end
      @(negedge clk);
      arm = 0; bus_valid = 0;
      idle(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule